// File: doc/BRIEF.md
# Power-Down Clock Stop Sequencer

This block sequences entry into and exit from a deep power-down state for a clock synthesizer. An asynchronous active-low request is brought into the CPU clock domain through a synchronizer. Every sequencing step is timed by that clock. When the request is seen, each output clock is gated off at a falling edge of its own source, so every clock stops in the low state without a runt pulse. The crystal and VCO enables are dropped only after every gate has reported back that it is closed.

On exit, the crystal enable rises first. The VCO enable follows after a crystal settling count, and the clock gates reopen after a further VCO settling count. Each gate reopens at a low phase of its source. The sequencer returns to its running state only after every gate has reported back that it is open again. A request that arrives during start-up is served only after that point. One status output shows when every clock is known to be held low.

Top module: `pwrdn_clk_seq`

## Requirements
- R1: While `rst_n` is low at a rising edge of `clk_cpu`, the block enters its running state: `xtal_en` and `vco_en` are 1, `clocks_held_low` is 0, and every gated output follows its source.
- R2: `pd_req_n` passes through two `clk_cpu` flops. If it falls 1 ns after a rising edge of `clk_cpu` while the block is running, `cpu_clk_out` gives exactly three more rising edges and then stays low.
- R3: No gated output is ever high while its source is low. Every change of a gated output coincides with a change of its source, so no shortened pulse appears.
- R4: `clocks_held_low` rises only at a time when every gated output is low. It is 1 whenever both oscillator enables are low. It is 0 again once the block is back in its running state.
- R5: `xtal_en` and `vco_en` fall only while `clocks_held_low` is 1. Every gated output stays low while either enable is low.
- R6: If `pd_req_n` rises 1 ns after a `clk_cpu` rising edge while both enables are low, `xtal_en` rises after the 3rd following rising edge.
- R7: `vco_en` rises `XTAL_SETTLE` rising edges after `xtal_en`. The settle counter never passes `XTAL_SETTLE+VCO_SETTLE-1`.
- R8: The first rising edge on `cpu_clk_out` comes at the (4+`XTAL_SETTLE`+`VCO_SETTLE`)th rising edge of `clk_cpu` after the release. The defaults keep this under 4 ms at 250 MHz.
- R9: A request that returns during start-up does not cut start-up short. Every gated output gives at least one rising edge before the enables fall again.
- R10: A request held low for only one to three `clk_cpu` cycles still produces a complete power-down and power-up cycle, and the clocks run afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_cpu | input | 1 | CPU clock; times the sequencer and is the source of `cpu_clk_out` |
| rst_n | input | 1 | Synchronous active-low reset |
| pd_req_n | input | 1 | Asynchronous active-low power-down request |
| aux_clk_in | input | NUM_AUX | Other source clocks (PCI, reference, 48 MHz) |
| cpu_clk_out | output | 1 | Gated CPU clock |
| aux_clk_out | output | NUM_AUX | Gated auxiliary clocks, bit for bit with `aux_clk_in` |
| xtal_en | output | 1 | Crystal oscillator enable |
| vco_en | output | 1 | VCO enable |
| clocks_held_low | output | 1 | All gates are confirmed closed |

## Verification
All timings are counted in rising edges of `clk_cpu` from an input change driven 1 ns after such an edge. The counts are: three CPU pulses after a request, `xtal_en` after the 3rd edge, `vco_en` `XTAL_SETTLE` edges later, and the first CPU pulse at edge 4+`XTAL_SETTLE`+`VCO_SETTLE`. The bench counts edges with its own counter. It samples enables at falling edges and gated clocks on a half-nanosecond grid that is offset from every clock edge, so each result is read after the edge that produces it. The auxiliary gates depend on clock phase, so they are checked with bounds that hold for any phase: no runt, held low before the oscillators drop, and at least one pulse during start-up. The sweep moves the request across many phase alignments of the auxiliary clocks.

// File: rtl/pds_pkg.sv
`timescale 1ns/1ps
// Package: shared sequencer state type for the power-down clock stop block.
// Assumes: nothing beyond SystemVerilog enum support.
package pds_pkg;
    typedef enum logic [2:0] {
        ST_RUN       = 3'd0,
        ST_STOP      = 3'd1,
        ST_OSC_OFF   = 3'd2,
        ST_OSC_START = 3'd3,
        ST_RELEASE   = 3'd4
    } pds_state_e;
endpackage

// File: rtl/pds_sync.sv
`timescale 1ns/1ps
// Module: multi-flop synchronizer for a vector of independent level signals.
// Assumes: each bit is a slow level (no bus coherence needed); synchronous
// active-low reset loads RST_VAL into every stage.
module pds_sync #(
    parameter int WIDTH   = 1,
    parameter int STAGES  = 2,
    parameter bit RST_VAL = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stage_q [STAGES];

    // Shift the sampled level through the chain of flops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) stage_q[s] <= {WIDTH{RST_VAL}};
        end else begin
            stage_q[0] <= d;
            for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
        end
    end

    assign q = stage_q[STAGES-1];
endmodule

// File: rtl/pds_clk_gate.sv
`timescale 1ns/1ps
// Module: glitch-free clock gate without a latch. The enable is registered on
// the falling edge of the gated clock, so it can only change while the clock
// is low; the output is the AND of clock and registered enable.
// Assumes: en_req may come from another domain when STAGES > 1; STAGES == 1
// is only for a request already in this clock's domain.
module pds_clk_gate #(
    parameter int STAGES = 2
) (
    input  logic clk_in,
    input  logic rst_n,
    input  logic en_req,
    output logic en_q,
    output logic clk_out
);
    generate
        if (STAGES == 1) begin : g_direct
            logic en_r;
            // Take the same-domain enable at the falling edge.
            always_ff @(negedge clk_in) begin
                if (!rst_n) en_r <= 1'b1;
                else        en_r <= en_req;
            end
            assign en_q = en_r;
        end else begin : g_sync
            logic [STAGES-1:0] chain_r;
            // Resynchronize the foreign enable on falling edges only.
            always_ff @(negedge clk_in) begin
                if (!rst_n) chain_r <= '1;
                else        chain_r <= {chain_r[STAGES-2:0], en_req};
            end
            assign en_q = chain_r[STAGES-1];
        end
    endgenerate

    assign clk_out = clk_in & en_q;
endmodule

// File: rtl/pds_fsm.sv
`timescale 1ns/1ps
// Module: power-down sequencer state machine. Closes all gates, waits for
// confirmation, drops the oscillators; on exit starts the crystal, then the
// VCO after XTAL_SETTLE cycles, then reopens gates after VCO_SETTLE more.
// Assumes: pd_act already synchronized; all_low / all_high are synchronized
// gate feedback; clock is the CPU clock; synchronous active-low reset.
module pds_fsm
    import pds_pkg::*;
#(
    parameter int XTAL_SETTLE = 400000,
    parameter int VCO_SETTLE  = 200000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pd_act,
    input  logic all_low,
    input  logic all_high,
    output logic gate_en_req,
    output logic xtal_en,
    output logic vco_en
);
    localparam int TOTAL = XTAL_SETTLE + VCO_SETTLE;
    localparam int CNT_W = $clog2(TOTAL + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TOTAL - 1);
    localparam logic [CNT_W-1:0] CNT_VCO  = CNT_W'(XTAL_SETTLE);

    pds_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q;

    // Choose the next sequencing step.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN:       if (pd_act) state_d = ST_STOP;
            ST_STOP:      if (all_low) state_d = ST_OSC_OFF;
            ST_OSC_OFF:   if (!pd_act) state_d = ST_OSC_START;
            ST_OSC_START: if (cnt_q == CNT_LAST) state_d = ST_RELEASE;
            ST_RELEASE:   if (all_high) state_d = ST_RUN;
            default:      state_d = ST_RUN;
        endcase
    end

    // Hold the current step.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    // Settle counter: cleared while off, counts while the oscillators start.
    always_ff @(posedge clk) begin
        if (!rst_n)                     cnt_q <= '0;
        else if (state_q == ST_OSC_OFF) cnt_q <= '0;
        else if (state_q == ST_OSC_START && cnt_q != CNT_LAST) cnt_q <= cnt_q + 1'b1;
    end

    // Decode the gate request and the oscillator enables from the step.
    always_comb begin
        gate_en_req = (state_q == ST_RUN) || (state_q == ST_RELEASE);
        xtal_en     = (state_q != ST_OSC_OFF);
        vco_en      = (state_q != ST_OSC_OFF) &&
                      !((state_q == ST_OSC_START) && (cnt_q < CNT_VCO));
    end

    // R1
    reset_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (state_q == ST_RUN && xtal_en && vco_en));

    // R7
    settle_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_OSC_START) |-> (cnt_q <= CNT_LAST));

    // R5
    off_gates_closed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_OSC_OFF) |-> all_low);
endmodule

// File: rtl/pwrdn_clk_seq.sv
`timescale 1ns/1ps
// Module: power-down clock stop sequencer top. Synchronizes the request,
// runs the sequencer on the CPU clock, gates the CPU clock and NUM_AUX other
// clocks, and feeds the gate states back as the held-low status.
// Assumes: every aux clock runs while its gate must close or open; rst_n
// is held long enough to be seen on a falling edge of every source clock.
module pwrdn_clk_seq #(
    parameter int NUM_AUX     = 3,
    parameter int SYNC_STAGES = 2,
    parameter int XTAL_SETTLE = 400000,
    parameter int VCO_SETTLE  = 200000
) (
    input  logic               clk_cpu,
    input  logic               rst_n,
    input  logic               pd_req_n,
    input  logic [NUM_AUX-1:0] aux_clk_in,
    output logic               cpu_clk_out,
    output logic [NUM_AUX-1:0] aux_clk_out,
    output logic               xtal_en,
    output logic               vco_en,
    output logic               clocks_held_low
);
    localparam int NUM_GATES = NUM_AUX + 1;

    logic                 pd_req_sync_n;
    logic                 pd_act;
    logic                 gate_en_req;
    logic [NUM_GATES-1:0] gate_open;
    logic [NUM_GATES-1:0] gate_open_fb;
    logic                 all_low;
    logic                 all_high;

    pds_sync #(.WIDTH(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_req_sync (
        .clk   (clk_cpu),
        .rst_n (rst_n),
        .d     (pd_req_n),
        .q     (pd_req_sync_n)
    );
    assign pd_act = ~pd_req_sync_n;

    pds_fsm #(.XTAL_SETTLE(XTAL_SETTLE), .VCO_SETTLE(VCO_SETTLE)) u_fsm (
        .clk         (clk_cpu),
        .rst_n       (rst_n),
        .pd_act      (pd_act),
        .all_low     (all_low),
        .all_high    (all_high),
        .gate_en_req (gate_en_req),
        .xtal_en     (xtal_en),
        .vco_en      (vco_en)
    );

    pds_clk_gate #(.STAGES(1)) u_cpu_gate (
        .clk_in  (clk_cpu),
        .rst_n   (rst_n),
        .en_req  (gate_en_req),
        .en_q    (gate_open[0]),
        .clk_out (cpu_clk_out)
    );

    generate
        for (genvar g = 0; g < NUM_AUX; g++) begin : g_aux
            pds_clk_gate #(.STAGES(SYNC_STAGES)) u_gate (
                .clk_in  (aux_clk_in[g]),
                .rst_n   (rst_n),
                .en_req  (gate_en_req),
                .en_q    (gate_open[g+1]),
                .clk_out (aux_clk_out[g])
            );
        end
    endgenerate

    pds_sync #(.WIDTH(NUM_GATES), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_fb_sync (
        .clk   (clk_cpu),
        .rst_n (rst_n),
        .d     (gate_open),
        .q     (gate_open_fb)
    );

    assign all_low         = ~|gate_open_fb;
    assign all_high        = &gate_open_fb;
    assign clocks_held_low = all_low;

    // R5
    osc_after_hold_chk: assert property (@(posedge clk_cpu) disable iff (!rst_n)
        ($fell(xtal_en) || $fell(vco_en)) |-> clocks_held_low);

    // R4
    hold_on_close_chk: assert property (@(posedge clk_cpu) disable iff (!rst_n)
        $rose(clocks_held_low) |-> !gate_en_req);
endmodule

// File: tb/pwrdn_clk_seq_bench.sv
`timescale 1ns/1ps
module pwrdn_clk_seq_bench;
    localparam int XS = 5;
    localparam int VS = 7;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pd_req_n = 1'b1;
    logic [2:0] aux_clk = 3'b000;
    logic       cpu_out;
    logic [2:0] aux_out;
    logic       xtal_en, vco_en, held_low;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 0;

    // monitor state
    bit mon_en = 0;
    bit arm_cpu = 0;
    int cpu_rise_cyc = -1;
    int glitch_err [4];
    int rise_cnt [4];
    int osc_err = 0;
    int hold_err = 0;

    pwrdn_clk_seq #(.NUM_AUX(3), .SYNC_STAGES(2), .XTAL_SETTLE(XS), .VCO_SETTLE(VS))
    u_pwrdn_clk_seq (
        .clk_cpu         (clk),
        .rst_n           (rst_n),
        .pd_req_n        (pd_req_n),
        .aux_clk_in      (aux_clk),
        .cpu_clk_out     (cpu_out),
        .aux_clk_out     (aux_out),
        .xtal_en         (xtal_en),
        .vco_en          (vco_en),
        .clocks_held_low (held_low)
    );

    always #2 clk = ~clk;
    always #4 aux_clk[0] = ~aux_clk[0];
    always #7 aux_clk[1] = ~aux_clk[1];
    always #3 aux_clk[2] = ~aux_clk[2];

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic clear_rises();
        for (int i = 0; i < 4; i++) rise_cnt[i] = 0;
    endtask

    // Poll falling edges until xtal_en equals lvl; n = cycles waited, -1 on timeout.
    task automatic wait_xtal(input logic lvl, input int limit, output int n);
        n = -1;
        for (int k = 0; k < limit; k++) begin
            @(negedge clk);
            if (xtal_en == lvl) begin n = k; break; end
        end
    endtask

    // Grid monitor, offset 0.25 ns from every clock edge.
    initial begin : monitor
        logic [3:0] src, gout, p_src, p_out;
        logic p_x, p_v, p_h;
        for (int i = 0; i < 4; i++) begin glitch_err[i] = 0; rise_cnt[i] = 0; end
        p_src = '0; p_out = '0; p_x = 1; p_v = 1; p_h = 0;
        #0.25;
        forever begin
            src  = {aux_clk, clk};
            gout = {aux_out, cpu_out};
            if (mon_en) begin
                for (int i = 0; i < 4; i++) begin
                    if (gout[i] && !src[i]) glitch_err[i]++;
                    if ((gout[i] != p_out[i]) && (src[i] == p_src[i])) glitch_err[i]++;
                    if (gout[i] && !p_out[i]) rise_cnt[i]++;
                end
                if (gout[0] && !p_out[0] && arm_cpu) begin
                    cpu_rise_cyc = cyc;
                    arm_cpu = 0;
                end
                if ((!xtal_en || !vco_en) && (gout != 4'b0)) osc_err++;
                if (p_x && !xtal_en && !held_low) osc_err++;
                if (p_v && !vco_en && !held_low) osc_err++;
                if (held_low && !p_h && (gout != 4'b0)) hold_err++;
            end
            p_src = src; p_out = gout; p_x = xtal_en; p_v = vco_en; p_h = held_low;
            #0.5;
        end
    end

    initial begin : watchdog
        #400000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : stimulus
        int n, t0;
        repeat (10) @(posedge clk);
        #1 rst_n = 1'b1;
        mon_en = 1;
        clear_rises();
        repeat (10) @(negedge clk);
        // R1 reset state
        check(xtal_en == 1'b1, "R1 xtal_en after reset", int'(xtal_en), 1);
        check(vco_en == 1'b1, "R1 vco_en after reset", int'(vco_en), 1);
        check(held_low == 1'b0, "R1 held_low after reset", int'(held_low), 0);
        for (int i = 0; i < 4; i++)
            check(rise_cnt[i] > 0, "R1 output runs after reset", rise_cnt[i], 1);

        // Full cycles over many aux phase alignments
        for (int p = 0; p < 9; p++) begin
            repeat (p) @(posedge clk);
            @(posedge clk); #1;
            pd_req_n = 1'b0;
            clear_rises();
            wait_xtal(1'b0, 200, n);
            check(n >= 0, "R5 oscillators turn off", n, 0);
            check(rise_cnt[0] == 3, "R2 cpu pulses after request", rise_cnt[0], 3);
            check(held_low == 1'b1, "R4 held_low while off", int'(held_low), 1);
            check(vco_en == 1'b0, "R5 vco_en off", int'(vco_en), 0);
            repeat (p % 3) @(posedge clk);
            @(posedge clk); #1;
            pd_req_n = 1'b1;
            t0 = cyc;
            arm_cpu = 1;
            cpu_rise_cyc = -1;
            wait_xtal(1'b1, 100, n);
            check(cyc - t0 == 3, "R6 xtal_en rise delay", cyc - t0, 3);
            for (int k = 0; k < 100; k++) begin
                if (vco_en) break;
                @(negedge clk);
            end
            check(cyc - t0 == 3 + XS, "R7 vco_en rise delay", cyc - t0, 3 + XS);
            repeat (40) @(negedge clk);
            check(cpu_rise_cyc - t0 == 4 + XS + VS, "R8 cpu restart delay",
                  cpu_rise_cyc - t0, 4 + XS + VS);
            check(held_low == 1'b0, "R4 held_low clears when running", int'(held_low), 0);
        end

        // Short requests: one to three cycles low
        for (int h = 1; h <= 3; h++) begin
            @(posedge clk); #1;
            pd_req_n = 1'b0;
            repeat (h) @(posedge clk);
            #1 pd_req_n = 1'b1;
            wait_xtal(1'b0, 200, n);
            check(n >= 0, "R10 short request turns oscillators off", n, 0);
            wait_xtal(1'b1, 200, n);
            check(n >= 0, "R10 short request restarts oscillators", n, 0);
            repeat (40) @(negedge clk);
            clear_rises();
            repeat (10) @(negedge clk);
            check(rise_cnt[0] > 0 && vco_en && !held_low, "R10 clocks run again",
                  rise_cnt[0], 1);
        end

        // Request returning during start-up
        for (int g = 1; g <= 16; g++) begin
            @(posedge clk); #1;
            pd_req_n = 1'b0;
            wait_xtal(1'b0, 200, n);
            @(posedge clk); #1;
            pd_req_n = 1'b1;
            clear_rises();
            repeat (g) @(posedge clk);
            #1 pd_req_n = 1'b0;
            wait_xtal(1'b1, 200, n);
            wait_xtal(1'b0, 300, n);
            check(n >= 0, "R9 second power-down reached", n, 0);
            for (int i = 0; i < 4; i++)
                check(rise_cnt[i] >= 1, "R9 output pulsed during start-up", rise_cnt[i], 1);
            @(posedge clk); #1;
            pd_req_n = 1'b1;
            repeat (50) @(negedge clk);
        end

        // Continuous monitors
        for (int i = 0; i < 4; i++)
            check(glitch_err[i] == 0, "R3 glitch-free output", glitch_err[i], 0);
        check(osc_err == 0, "R5 oscillator order", osc_err, 0);
        check(hold_err == 0, "R4 held_low only with outputs low", hold_err, 0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule